// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of a general purpose timer; the timer holds three of them. On each cycle where the shared counter advances (a tick strobe), the channel checks whether the counter equals its compare value. When the two are equal, it raises a sticky event flag. It also applies the pin action chosen by a three-bit mode field to its output pin. The pin can hold off, toggle, drive low, drive high, or emit a low pulse that lasts one counter tick.

Software can force the programmed pin action without a counter match. A forced action leaves the flag untouched. The flag is cleared by a clear strobe, and a match in the same cycle wins over the clear. The interrupt request is the flag gated by an enable. All inputs are plain control levels or strobes, already decoded from the register bus elsewhere, so the block has no back-pressure. Every output comes straight from a register or from one AND gate.

Top module: `ocmp_channel`

## Requirements
- R1: After reset, `pin_o`, `flag_o` and `irq_o` are all 0.
- R2: A match is a cycle where `tick_i` is 1 and `count_i` equals `cmp_val_i`. A match sets `flag_o` at the next clock edge. Equal values while `tick_i` is 0 do not set the flag.
- R3: `flag_o` stays set until `flag_clr_i` is 1 for a cycle, and then it reads 0 at the next edge. If a match and a clear occur in the same cycle, the flag stays set.
- R4: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en_i` is 1. This holds in the same cycle, with no added delay.
- R5: With `mode_i` = 3'b000 the pin is disconnected. `pin_o` reads 0 one edge later and ignores both matches and force strobes. Matches still set the flag.
- R6: With `mode_i` = 3'b001, each match or force inverts `pin_o` at the next edge. With no event, the pin holds its level.
- R7: With `mode_i` = 3'b010 an event drives `pin_o` to 0, and with `mode_i` = 3'b011 an event drives it to 1. In both cases the new level appears at the next edge and is then held.
- R8: With `mode_i[2]` = 1 (pulse mode), `pin_o` idles at 1 from the edge after the mode is selected. An event drives it to 0 at the next edge. It stays at 0 until the edge that closes the next `tick_i` cycle, then returns to 1.
- R9: `force_i` = 1 applies the current mode's pin action at the next edge and never sets `flag_o`. `force_i` = 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | 32 | Current counter value |
| tick_i | input | 1 | Counter advance strobe; qualifies a match |
| cmp_val_i | input | 32 | Compare value |
| mode_i | input | 3 | Pin action: 000 off, 001 toggle, 010 low, 011 high, 1xx low pulse |
| force_i | input | 1 | Force strobe: apply the pin action without setting the flag |
| flag_clr_i | input | 1 | Flag clear strobe |
| irq_en_i | input | 1 | Interrupt enable |
| pin_o | output | 1 | Compare output pin |
| flag_o | output | 1 | Sticky compare event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The state inside the block is small: the flag, the pin level and a pulse-armed bit. Any corruption of that state shows at the ports within one or two edges. A wrong flag shows up on `flag_o` and `irq_o` at the edge after the faulty match or clear. A wrong pin action shows on `pin_o` at the edge after the event. A stuck pulse-armed bit shows as a pin that fails to return high at the end of the next tick cycle, or that never leaves its idle high level. The directed scenarios therefore sample one edge after each event and at each tick boundary in pulse mode.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

  typedef enum logic [2:0] {
    PA_OFF    = 3'd0,
    PA_TOGGLE = 3'd1,
    PA_LOW    = 3'd2,
    PA_HIGH   = 3'd3,
    PA_PULSE  = 3'd4
  } pin_act_e;

  // Any mode with the top bit set selects the pulse action.
  function automatic pin_act_e decode_mode(input logic [2:0] mode);
    if (mode[2])
      return PA_PULSE;
    case (mode[1:0])
      2'd1:    return PA_TOGGLE;
      2'd2:    return PA_LOW;
      2'd3:    return PA_HIGH;
      default: return PA_OFF;
    endcase
  endfunction

endpackage

// File: rtl/ocmp_match.sv
module ocmp_match #(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             tick_i,
  input  logic             force_i,
  output logic             match_o,
  output logic             event_o
);
  // A match needs both a tick and equal values.
  logic equal;
  assign equal   = (count_i == cmp_val_i);
  assign match_o = tick_i & equal;
  assign event_o = match_o | force_i;
endmodule

// File: rtl/ocmp_flag.sv
module ocmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_o <= 1'b0;
    else if (set_i)
      flag_o <= 1'b1;
    else if (clr_i)
      flag_o <= 1'b0;
  end
endmodule

// File: rtl/ocmp_pin.sv
module ocmp_pin
  import ocmp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_act_e act_i,
  input  logic     event_i,
  input  logic     tick_i,
  output logic     pin_o
);
  // Set while a low pulse waits for the tick that ends it.
  logic pulse_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_o       <= 1'b0;
      pulse_armed <= 1'b0;
    end else begin
      case (act_i)
        PA_PULSE: begin
          if (event_i) begin
            pin_o       <= 1'b0;
            pulse_armed <= 1'b1;
          end else if (pulse_armed) begin
            if (tick_i) begin
              pin_o       <= 1'b1;
              pulse_armed <= 1'b0;
            end
          end else begin
            pin_o <= 1'b1;
          end
        end
        PA_TOGGLE: begin
          pulse_armed <= 1'b0;
          if (event_i) pin_o <= ~pin_o;
        end
        PA_LOW: begin
          pulse_armed <= 1'b0;
          if (event_i) pin_o <= 1'b0;
        end
        PA_HIGH: begin
          pulse_armed <= 1'b0;
          if (event_i) pin_o <= 1'b1;
        end
        default: begin
          pin_o       <= 1'b0;
          pulse_armed <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
  import ocmp_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  cmp_val_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              force_i,
  input  logic              flag_clr_i,
  input  logic              irq_en_i,
  output logic              pin_o,
  output logic              flag_o,
  output logic              irq_o
);
  localparam int ModeBits = (MODE_W < 3) ? MODE_W : 3;

  logic [2:0] mode3;
  pin_act_e   act;
  logic       match;
  logic       evt;

  // The mode is padded or trimmed to the three bits the decoder uses.
  always_comb begin
    mode3 = '0;
    mode3[ModeBits-1:0] = mode_i[ModeBits-1:0];
  end

  assign act = decode_mode(mode3);

  ocmp_match #(.CNT_W(CNT_W)) u_match (
    .count_i   (count_i),
    .cmp_val_i (cmp_val_i),
    .tick_i    (tick_i),
    .force_i   (force_i),
    .match_o   (match),
    .event_o   (evt)
  );

  ocmp_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (match),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o)
  );

  ocmp_pin u_pin (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_i   (act),
    .event_i (evt),
    .tick_i  (tick_i),
    .pin_o   (pin_o)
  );

  assign irq_o = flag_o & irq_en_i;
endmodule

// File: rtl/ocmp_channel_chk.sv
module ocmp_channel_chk #(
  parameter int CNT_W  = 32,
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  count_i,
  input logic              tick_i,
  input logic [CNT_W-1:0]  cmp_val_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              force_i,
  input logic              flag_clr_i,
  input logic              irq_en_i,
  input logic              pin_o,
  input logic              flag_o,
  input logic              irq_o
);
  logic hit;
  assign hit = tick_i && (count_i == cmp_val_i);

  assert_match_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_o);

  assert_clear_drops_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !hit) |=> !flag_o);

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i) |=> flag_o);

  assert_off_pin_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b000) |=> !pin_o);

  assert_toggle_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b001 && hit) |=> (pin_o != $past(pin_o)));

  assert_pulse_ends_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[2] && tick_i && !hit && !force_i) |=> pin_o);

  assert_force_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_i && !hit && !flag_o) |=> !flag_o);
endmodule

bind ocmp_channel ocmp_channel_chk #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_chk (.*);

// File: tb/tb_ocmp_channel.sv
module tb_ocmp_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] count_i = '0;
  logic        tick_i = 1'b0;
  logic [31:0] cmp_val_i = 32'd5;
  logic [2:0]  mode_i = 3'b000;
  logic        force_i = 1'b0;
  logic        flag_clr_i = 1'b0;
  logic        irq_en_i = 1'b0;
  logic        pin_o, flag_o, irq_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ocmp_channel dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // Apply inputs after the falling edge, then sample just after the next rising edge.
  task automatic drive(input logic [31:0] cnt, input logic tk,
                       input logic frc, input logic clr);
    @(negedge clk);
    count_i = cnt; tick_i = tk; force_i = frc; flag_clr_i = clr;
    @(posedge clk); #1;
    tick_i = 1'b0; force_i = 1'b0; flag_clr_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 pin", pin_o, 1'b0);
    chk("R1 flag", flag_o, 1'b0);
    chk("R1 irq", irq_o, 1'b0);
  endtask

  task automatic t_match_flag;
    mode_i = 3'b000;
    drive(32'd5, 1'b0, 1'b0, 1'b0);
    chk("R2 no tick no flag", flag_o, 1'b0);
    drive(32'd5, 1'b1, 1'b0, 1'b0);
    chk("R2 match sets flag", flag_o, 1'b1);
    chk("R5 off pin low", pin_o, 1'b0);
    chk("R4 irq gated off", irq_o, 1'b0);
    irq_en_i = 1'b1; #1;
    chk("R4 irq on", irq_o, 1'b1);
    irq_en_i = 1'b0;
  endtask

  task automatic t_clear;
    drive(32'd0, 1'b0, 1'b0, 1'b0);
    chk("R3 sticky", flag_o, 1'b1);
    drive(32'd0, 1'b0, 1'b0, 1'b1);
    chk("R3 clear", flag_o, 1'b0);
    drive(32'd5, 1'b1, 1'b0, 1'b1);
    chk("R3 match beats clear", flag_o, 1'b1);
    drive(32'd0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_toggle;
    mode_i = 3'b001;
    drive(32'd5, 1'b1, 1'b0, 1'b0);
    chk("R6 toggle up", pin_o, 1'b1);
    drive(32'd6, 1'b1, 1'b0, 1'b0);
    chk("R6 no match holds", pin_o, 1'b1);
    drive(32'd5, 1'b1, 1'b0, 1'b0);
    chk("R6 toggle down", pin_o, 1'b0);
  endtask

  task automatic t_set_clear;
    mode_i = 3'b011;
    drive(32'd5, 1'b1, 1'b0, 1'b0);
    chk("R7 set", pin_o, 1'b1);
    mode_i = 3'b010;
    drive(32'd4, 1'b1, 1'b0, 1'b0);
    chk("R7 low mode holds", pin_o, 1'b1);
    drive(32'd5, 1'b1, 1'b0, 1'b0);
    chk("R7 clear", pin_o, 1'b0);
  endtask

  task automatic t_pulse;
    mode_i = 3'b100;
    drive(32'd0, 1'b0, 1'b0, 1'b0);
    chk("R8 idle high", pin_o, 1'b1);
    drive(32'd5, 1'b1, 1'b0, 1'b0);
    chk("R8 pulse low", pin_o, 1'b0);
    drive(32'd5, 1'b0, 1'b0, 1'b0);
    chk("R8 low until tick", pin_o, 1'b0);
    drive(32'd6, 1'b1, 1'b0, 1'b0);
    chk("R8 back high", pin_o, 1'b1);
  endtask

  task automatic t_force;
    mode_i = 3'b010;
    drive(32'd0, 1'b0, 1'b0, 1'b1);
    chk("R9 flag cleared first", flag_o, 1'b0);
    drive(32'd0, 1'b0, 1'b1, 1'b0);
    chk("R9 force low", pin_o, 1'b0);
    chk("R9 force no flag", flag_o, 1'b0);
    mode_i = 3'b011;
    drive(32'd0, 1'b0, 1'b0, 1'b0);
    chk("R9 force zero no effect", pin_o, 1'b0);
    drive(32'd0, 1'b0, 1'b1, 1'b0);
    chk("R9 force high", pin_o, 1'b1);
    mode_i = 3'b000;
    drive(32'd0, 1'b0, 1'b1, 1'b0);
    chk("R5 off ignores force", pin_o, 1'b0);
    chk("R9 off force no flag", flag_o, 1'b0);
  endtask

  initial begin
    #1;
    t_reset();
    #20;
    rst_n = 1'b1;
    t_match_flag();
    t_clear();
    t_toggle();
    t_set_clear();
    t_pulse();
    t_force();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule